// File: doc/BRIEF.md
# Port Change Wake-up Detector

This block watches a parallel input port and reports when any input pin moves away from a reference value that software captured earlier. Software captures the reference by reading the port. It then sets the detector's enable bit. From that point any mismatch on a pin configured as an input sets a sticky change flag. The flag raises an interrupt request when the global interrupt enable is on. Reading the port again reloads the reference, which rearms the detector once software has cleared the flag.

While the core sleeps, a mismatch produces a wake request. This needs the detector enabled and the watchdog hardware option set. The wake path is combinational from the raw pins, the reference, the enable and the flag, so it still works with the core clock stopped. Along with the wake request, the block tells the core where to go next. It resumes at the change-interrupt vector (0x008) when global interrupts are enabled. Otherwise it continues with the next instruction.

Every pin here is a plain control or status pin. The block moves no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pcw_detector`

## Requirements
- R1: After reset the change flag, the enable bit, the reference and the synchronized port value are all 0. `irq_req`, `wake_req`, `wake_vec` and `wake_next` are all low.
- R2: `port_val` shows `port_in` after exactly two rising clock edges, through a two-stage synchronizer.
- R3: A rising edge with `port_rd` high loads the reference with the `port_val` present at that edge. After that, an unchanged port sets no flag.
- R4: With the enable bit at 1, a difference between `port_val` and the reference on any bit whose `dir_mask` bit is 1 sets `chg_flag` at the next rising edge. It takes three edges from a pin change to the flag.
- R5: Bits whose `dir_mask` bit is 0 (pins used as outputs) never cause a flag or a wake request.
- R6: The enable bit is written with `ctl_en_d` on an edge where `ctl_wr` is high, and it reads back on `func_en`. With the enable bit at 0, no difference sets the flag.
- R7: Once set, `chg_flag` stays set until an edge with `flag_clr` high. If a difference is still present on that same edge, the set wins and the flag stays 1.
- R8: `irq_req` is high exactly when `chg_flag`, the enable bit and `gie` are all high. It follows `gie` with no clock edge.
- R9: `wake_req` is high when `sleeping`, `wdt_opt` and the enable bit are all high and either `chg_flag` is set or a raw `port_in` input bit differs from the reference. It needs no clock edge. With `wdt_opt` low or `sleeping` low it stays 0.
- R10: While `wake_req` is high, `wake_vec` (go to vector 0x008) equals `gie` and `wake_next` (continue with the next instruction) equals the inverse of `gie`. Both are 0 whenever `wake_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_in | input | 8 | Raw port pin levels |
| dir_mask | input | 8 | 1 = pin is an input and is compared |
| port_rd | input | 1 | Software read of the port; reloads the reference |
| ctl_wr | input | 1 | Write strobe for the enable bit |
| ctl_en_d | input | 1 | Value written to the enable bit |
| flag_clr | input | 1 | Clears the change flag |
| gie | input | 1 | Global interrupt enable |
| sleeping | input | 1 | Core is in sleep mode |
| wdt_opt | input | 1 | Watchdog hardware enable option |
| port_val | output | 8 | Synchronized port value (read data) |
| func_en | output | 1 | Enable bit readback |
| chg_flag | output | 1 | Sticky change flag |
| irq_req | output | 1 | Change interrupt request |
| wake_req | output | 1 | Wake request to the sleeping core |
| wake_vec | output | 1 | After wake, jump to vector 0x008 |
| wake_next | output | 1 | After wake, continue with the next instruction |

## Verification
The hardest situation to reach from the ports is a wake caused by a raw pin change before any clock edge has passed it through the synchronizer. That is the case a stopped core clock creates. To reach it, the stimulus first arms the detector and clears the flag. It then raises `sleeping`, changes a pin just after a falling edge, and samples `wake_req` a few nanoseconds later, well before the next rising edge. A second hard case is a clear that arrives while the mismatch is still present. The stimulus forces it by pulsing `flag_clr` before rereading the port, and only then pulses the reread followed by a clear.

// File: rtl/pcw_pkg.sv
package pcw_pkg;

  localparam int unsigned VECTOR_ADDR = 12'h008;

  typedef enum logic [1:0] {
    WK_IDLE   = 2'b00,
    WK_VECTOR = 2'b01,
    WK_RESUME = 2'b10
  } wake_sel_e;

  function automatic wake_sel_e wake_decide(input logic req, input logic ie);
    if (!req) return WK_IDLE;
    return ie ? WK_VECTOR : WK_RESUME;
  endfunction

endpackage

// File: rtl/pcw_sync.sv
module pcw_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [N-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[N-2:0], d[b]};
    end
    assign q[b] = chain[N-1];
  end
endmodule

// File: rtl/pcw_compare.sv
module pcw_compare #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reload,
  input  logic [W-1:0] sync_val,
  input  logic [W-1:0] raw_val,
  input  logic [W-1:0] mask,
  output logic [W-1:0] ref_q,
  output logic         sync_hit,
  output logic         raw_hit
);
  logic [W-1:0] sync_diff, raw_diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ref_q <= '0;
    else if (reload) ref_q <= sync_val;
  end

  // only input-configured pins take part
  assign sync_diff = (sync_val ^ ref_q) & mask;
  assign raw_diff  = (raw_val  ^ ref_q) & mask;
  assign sync_hit  = |sync_diff;
  assign raw_hit   = |raw_diff;
endmodule

// File: rtl/pcw_flag.sv
module pcw_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_d,
  input  logic hit,
  input  logic clr,
  output logic en_q,
  output logic flag_q
);
  logic set_now;

  assign set_now = en_q & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (ctl_wr) en_q <= ctl_d;
      // set has priority over a simultaneous clear
      flag_q <= set_now | (flag_q & ~clr);
    end
  end
endmodule

// File: rtl/pcw_detector.sv
module pcw_detector #(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_in,
  input  logic [PORT_W-1:0] dir_mask,
  input  logic              port_rd,
  input  logic              ctl_wr,
  input  logic              ctl_en_d,
  input  logic              flag_clr,
  input  logic              gie,
  input  logic              sleeping,
  input  logic              wdt_opt,
  output logic [PORT_W-1:0] port_val,
  output logic              func_en,
  output logic              chg_flag,
  output logic              irq_req,
  output logic              wake_req,
  output logic              wake_vec,
  output logic              wake_next
);
  import pcw_pkg::*;

  logic [PORT_W-1:0] ref_val;
  logic              sync_hit, raw_hit;
  wake_sel_e         wsel;

  pcw_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(port_in), .q(port_val)
  );

  pcw_compare #(.W(PORT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .reload(port_rd),
    .sync_val(port_val), .raw_val(port_in), .mask(dir_mask),
    .ref_q(ref_val), .sync_hit(sync_hit), .raw_hit(raw_hit)
  );

  pcw_flag u_flag (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_d(ctl_en_d),
    .hit(sync_hit), .clr(flag_clr), .en_q(func_en), .flag_q(chg_flag)
  );

  assign irq_req  = chg_flag & func_en & gie;
  // raw path keeps wake alive while the core clock is stopped
  assign wake_req = sleeping & wdt_opt & func_en & (chg_flag | raw_hit);

  assign wsel      = wake_decide(wake_req, gie);
  assign wake_vec  = (wsel == WK_VECTOR);
  assign wake_next = (wsel == WK_RESUME);
endmodule

// File: rtl/pcw_detector_chk.sv
module pcw_detector_chk #(
  parameter int unsigned PORT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_rd,
  input logic              flag_clr,
  input logic              gie,
  input logic              sleeping,
  input logic [PORT_W-1:0] dir_mask,
  input logic [PORT_W-1:0] port_val,
  input logic [PORT_W-1:0] ref_val,
  input logic              func_en,
  input logic              chg_flag,
  input logic              irq_req,
  input logic              wake_req,
  input logic              wake_vec,
  input logic              wake_next
);
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd |=> (ref_val == $past(port_val)));

  a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
    (func_en && (|((port_val ^ ref_val) & dir_mask))) |=> chg_flag);

  a_r6_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!func_en && !chg_flag) |=> !chg_flag);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag && !flag_clr) |=> chg_flag);

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (gie && chg_flag));

  a_r9_awake_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    !sleeping |-> !wake_req);

  a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wake_vec, wake_next}) == (wake_req ? 1 : 0));
endmodule

bind pcw_detector pcw_detector_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_rd(port_rd), .flag_clr(flag_clr),
  .gie(gie), .sleeping(sleeping), .dir_mask(dir_mask), .port_val(port_val),
  .ref_val(ref_val), .func_en(func_en), .chg_flag(chg_flag),
  .irq_req(irq_req), .wake_req(wake_req), .wake_vec(wake_vec),
  .wake_next(wake_next)
);

// File: tb/sim_pcw_detector.sv
module sim_pcw_detector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] port_in = '0, dir_mask = 8'hFF;
  logic       port_rd = 0, ctl_wr = 0, ctl_en_d = 0, flag_clr = 0;
  logic       gie = 0, sleeping = 0, wdt_opt = 0;
  logic [7:0] port_val;
  logic       func_en, chg_flag, irq_req, wake_req, wake_vec, wake_next;
  int         errors = 0, checks = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  pcw_detector u0 (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .dir_mask(dir_mask),
    .port_rd(port_rd), .ctl_wr(ctl_wr), .ctl_en_d(ctl_en_d),
    .flag_clr(flag_clr), .gie(gie), .sleeping(sleeping), .wdt_opt(wdt_opt),
    .port_val(port_val), .func_en(func_en), .chg_flag(chg_flag),
    .irq_req(irq_req), .wake_req(wake_req), .wake_vec(wake_vec),
    .wake_next(wake_next)
  );

  // {mask, reference value, new value, enable, expected flag}
  localparam logic [25:0] VEC [8] = '{
    {8'hFF, 8'h00, 8'h01, 1'b1, 1'b1},
    {8'hFF, 8'hA5, 8'hA5, 1'b1, 1'b0},
    {8'h0F, 8'h00, 8'hF0, 1'b1, 1'b0},
    {8'h0F, 8'h00, 8'h08, 1'b1, 1'b1},
    {8'hFF, 8'h3C, 8'h3D, 1'b0, 1'b0},
    {8'h80, 8'h00, 8'h80, 1'b1, 1'b1},
    {8'h00, 8'h00, 8'hFF, 1'b1, 1'b0},
    {8'hFF, 8'hFF, 8'h7F, 1'b1, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_rd();  port_rd = 1;  tick(1); port_rd = 0;  endtask
  task automatic pulse_clr(); flag_clr = 1; tick(1); flag_clr = 0; endtask
  task automatic write_en(input logic v);
    ctl_en_d = v; ctl_wr = 1; tick(1); ctl_wr = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(2);
    // R1: reset state
    check("R1 flag", chg_flag, 0);
    check("R1 enable", func_en, 0);
    check("R1 port_val", port_val, 0);
    check("R1 outputs", {irq_req, wake_req, wake_vec, wake_next}, 0);
    rst_n = 1;
    tick(1);

    // R2: two-edge synchronizer latency
    port_in = 8'h55;
    tick(1);
    check("R2 one edge", port_val, 8'h00);
    tick(1);
    check("R2 two edges", port_val, 8'h55);

    foreach (VEC[i]) begin
      write_en(1'b0);
      dir_mask = VEC[i][25:18];
      port_in  = VEC[i][17:10];
      tick(3);
      pulse_rd();
      pulse_clr();
      write_en(VEC[i][1]);
      check("R6 readback", func_en, VEC[i][1]);
      port_in = VEC[i][9:2];
      tick(2);
      check("R4 no early flag", chg_flag, 0);
      tick(1);
      check("R4/R5/R6 vector flag", chg_flag, VEC[i][0]);
    end

    // state: mask FF, ref FF, port 7F, en 1, flag 1
    tick(4);
    check("R7 hold", chg_flag, 1);
    pulse_clr();
    check("R7 set wins over clear", chg_flag, 1);
    pulse_rd();
    pulse_clr();
    check("R3 cleared after reload", chg_flag, 0);
    tick(3);
    check("R3 no flag after reload", chg_flag, 0);

    // R8
    gie = 1;
    port_in = 8'h7E;
    tick(3);
    check("R8 irq with gie", irq_req, 1);
    gie = 0; #1;
    check("R8 irq without gie", irq_req, 0);

    // R9/R10 with flag set
    sleeping = 1; wdt_opt = 1; gie = 1; #1;
    check("R9 wake on flag", wake_req, 1);
    check("R10 vector", {wake_vec, wake_next}, 2'b10);
    gie = 0; #1;
    check("R10 next instruction", {wake_vec, wake_next}, 2'b01);
    @(negedge clk);
    pulse_rd();
    pulse_clr();
    check("R9 no wake when matched", wake_req, 0);
    check("R10 idle", {wake_vec, wake_next}, 2'b00);

    // R9 raw path, before any clock edge
    port_in = 8'h7C; #2;
    check("R9 raw wake without edge", wake_req, 1);
    wdt_opt = 0; #1;
    check("R9 no wake without option", wake_req, 0);
    wdt_opt = 1; sleeping = 0; #1;
    check("R9 no wake when awake", wake_req, 0);

    // R5 raw path ignores output pins
    @(negedge clk);
    tick(3);
    pulse_rd();
    pulse_clr();
    dir_mask = 8'h0F; sleeping = 1;
    port_in = 8'hFC; #2;
    check("R5 masked pin no wake", wake_req, 0);
    tick(3);
    check("R5 masked pin no flag", chg_flag, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule